// File: doc/BRIEF.md
# Key-Protected Watchdog Control Front End

This block sits behind a simple 16-bit register bus and guards a watchdog's control register with a two-key unlock ritual. Software first writes one key word and then a second key word to a dedicated unlock register. The second key must arrive shortly after the first. Only then does a bounded window open in which the control register accepts writes. Any deviation pulls a one-cycle reset request and relocks the block.

Bit 0 of the control register enables a countdown watchdog. While that bit is set, the counter runs down from a timeout parameter. When it is exhausted it raises the same reset request and reloads. Software typically uses the unlock window to clear bit 0 early in boot.

Top module: `wdog_keylock`

## Requirements
- R1: While and after reset, a read of the control register (byte offset 0x0) returns 0x0001 and `rst_req` is low.
- R2: Writing 0xC520 and then 0xD928 to the unlock register (byte offset 0xE) unlocks the control register when the second write lands 1 to 20 cycles after the first.
- R3: If the second key has not been written by 20 cycles after the first, `rst_req` pulses high for one cycle. The pulse is registered at the clock edge 20 cycles after the first key.
- R4: A write to the unlock register of a value other than the key expected next causes a one-cycle `rst_req` pulse in the following cycle. This covers the second key with no first key, a repeated first key, and any other word.
- R5: After a successful unlock, a control write is accepted at the 1st through the 256th clock edge following the second key. A write at the 257th edge or later is ignored, and the block relocks by itself.
- R6: A control write while locked leaves the register unchanged.
- R7: With `bus_rd` high and the control address selected, `bus_rdata` shows the control register whether locked or not. Otherwise it is zero.
- R8: With bit 0 set, `rst_req` pulses TIMEOUT+1 cycles after reset release, and then every TIMEOUT+1 cycles after that.
- R9: With bit 0 clear, the watchdog never requests a reset.
- R10: Every `rst_req` pulse returns the block to the locked state, so a control write in the pulse cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Combinational read data |
| rst_req | output | 1 | Registered one-cycle system reset request |

## Verification
A stale or wrong unlock phase shows at the ports in one of two ways. A control write that is wrongly accepted or wrongly refused shows on the very next read-back. A key word that is wrongly judged shows as a missing or extra `rst_req` pulse one cycle after it. Errors in the gap or window counter move the edge of acceptance by one cycle, so the bench probes both sides of the 20-cycle and 256-cycle limits. A wrong watchdog count shows as a pulse that is early or late against the TIMEOUT+1 period, measured exactly from reset release.

// File: rtl/wdog_keylock.sv
module wdog_keylock #(
  parameter int          ADDR_W      = 4,
  parameter int          CTRL_ADDR   = 0,
  parameter int          KEY_ADDR    = 14,
  parameter logic [15:0] KEY_FIRST   = 16'hC520,
  parameter logic [15:0] KEY_SECOND  = 16'hD928,
  parameter int          KEY_GAP     = 20,
  parameter int          OPEN_CYCLES = 256,
  parameter logic [15:0] TIMEOUT     = 16'd1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [15:0]       bus_rdata,
  output logic              rst_req
);
  localparam int SPAN = (KEY_GAP > OPEN_CYCLES) ? KEY_GAP : OPEN_CYCLES;
  localparam int TW   = $clog2(SPAN + 1);
  localparam logic [1:0] P_LOCKED = 2'd0, P_KEYA = 2'd1, P_OPEN = 2'd2;

  logic [1:0]    phase;
  logic [TW-1:0] tick;
  logic [15:0]   ctrl_q, wd_cnt;

  wire key_wr   = bus_wr && bus_addr == ADDR_W'(KEY_ADDR);
  wire ctl_wr   = bus_wr && bus_addr == ADDR_W'(CTRL_ADDR);
  wire gap_last = phase == P_KEYA && tick == TW'(KEY_GAP - 1);
  wire win_last = phase == P_OPEN && tick == TW'(OPEN_CYCLES - 1);
  wire key_ok   = (phase != P_KEYA && bus_wdata == KEY_FIRST) ||
                  (phase == P_KEYA && bus_wdata == KEY_SECOND);
  wire bad_key  = key_wr && !key_ok;
  wire gap_fail = gap_last && !key_wr;
  wire dog_fire = ctrl_q[0] && wd_cnt == 16'd0;
  wire fail     = bad_key || gap_fail || dog_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_LOCKED;
      tick  <= '0;
    end else if (fail) begin
      phase <= P_LOCKED;
      tick  <= '0;
    end else if (key_wr) begin
      phase <= (phase == P_KEYA) ? P_OPEN : P_KEYA;
      tick  <= '0;
    end else if (phase != P_LOCKED) begin
      tick <= tick + TW'(1);
      if (win_last) phase <= P_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ctrl_q <= 16'h0001;
    else if (ctl_wr && phase == P_OPEN && !fail) ctrl_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wd_cnt <= TIMEOUT;
    else if (!ctrl_q[0] || fail)     wd_cnt <= TIMEOUT;
    else                             wd_cnt <= wd_cnt - 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= fail;
  end

  assign bus_rdata = (bus_rd && bus_addr == ADDR_W'(CTRL_ADDR)) ? ctrl_q : 16'h0000;
endmodule

// File: rtl/wdog_keylock_chk.sv
module wdog_keylock_chk #(
  parameter int          ADDR_W     = 4,
  parameter int          CTRL_ADDR  = 0,
  parameter int          KEY_ADDR   = 14,
  parameter logic [15:0] KEY_FIRST  = 16'hC520,
  parameter logic [15:0] KEY_SECOND = 16'hD928,
  parameter int          KEY_GAP    = 20,
  parameter int          TW         = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [15:0]       bus_rdata,
  input logic              rst_req,
  input logic [15:0]       ctrl_q,
  input logic [1:0]        phase,
  input logic [TW-1:0]     tick
);
  wire at_key  = bus_wr && bus_addr == ADDR_W'(KEY_ADDR);
  wire at_ctrl = bus_addr == ADDR_W'(CTRL_ADDR);

  p_bad_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && at_key && bus_wdata != KEY_FIRST) |=> rst_req);

  p_bad_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1 && at_key && bus_wdata != KEY_SECOND) |=> rst_req);

  p_gap_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1 && tick == TW'(KEY_GAP - 1) && !at_key) |=> rst_req);

  p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && bus_wr && at_ctrl) |=> $stable(ctrl_q));

  p_relock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && bus_wr && at_ctrl) |=> $stable(ctrl_q));

  p_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && at_ctrl) |-> bus_rdata == ctrl_q);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !at_key && phase != 2'd1) |=> !rst_req);
endmodule

bind wdog_keylock wdog_keylock_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .KEY_ADDR(KEY_ADDR),
  .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND), .KEY_GAP(KEY_GAP), .TW(TW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .rst_req(rst_req),
  .ctrl_q(ctrl_q), .phase(phase), .tick(tick)
);

// File: tb/wdog_keylock_test.sv
module wdog_keylock_test;
  localparam int CLK_PERIOD = 10;
  localparam int T = 40;
  localparam logic [3:0] A_CTRL = 4'h0, A_KEY = 4'hE;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic rst_req;
  int checks = 0, failures = 0, pulses = 0;

  wdog_keylock #(.TIMEOUT(16'(T))) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .rst_req(rst_req));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (rst_n && rst_req) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(output logic [15:0] d);
    bus_addr = A_CTRL; bus_rd = 1;
    #1 d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic relock();
    wr(A_KEY, 16'h1234);
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n, p0;
    idle(2);
    rd(v);
    chk(v == 16'h0001, "R1 ctrl in reset", v, 16'h0001);
    chk(rst_req == 0, "R1 rst_req in reset", rst_req, 0);
    rst_n = 1;
    rd(v);
    chk(v == 16'h0001, "R1 ctrl after reset", v, 16'h0001);

    n = 0;
    do begin @(negedge clk); n++; end while (!rst_req && n < 1000);
    chk(n == T + 1, "R8 first watchdog pulse", n, T + 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!rst_req && n < 1000);
    chk(n == T + 1, "R8 watchdog period", n, T + 1);

    wr(A_KEY, 16'hC520); wr(A_KEY, 16'hD928); wr(A_CTRL, 16'h0000);
    rd(v);
    chk(v == 16'h0000, "R9 disable write", v, 0);
    p0 = pulses;
    idle(300);
    chk(pulses == p0, "R9 no watchdog pulse while disabled", pulses, p0);

    wr(A_CTRL, 16'hFFF0);
    rd(v);
    chk(v == 16'h0000, "R6 locked write ignored / R7 read while locked", v, 0);

    for (int k = 1; k <= 20; k++) begin
      p0 = pulses;
      wr(A_KEY, 16'hC520);
      idle(k - 1);
      wr(A_KEY, 16'hD928);
      wr(A_CTRL, 16'(k << 4));
      rd(v);
      chk(v == 16'(k << 4), "R2 unlock within gap", v, k << 4);
      chk(pulses == p0, "R2 no reset on good sequence", pulses, p0);
    end
    relock();

    wr(A_KEY, 16'hC520);
    idle(19);
    chk(rst_req == 0, "R3 no pulse before gap ends", rst_req, 0);
    bus_addr = A_CTRL; bus_wdata = 16'h0AA0; bus_wr = 1;
    @(negedge clk);
    chk(rst_req == 1, "R3 pulse at gap end", rst_req, 1);
    @(negedge clk);
    bus_wr = 0;
    chk(rst_req == 0, "R3 pulse one cycle", rst_req, 0);
    rd(v);
    chk(v == 16'h0140, "R10 write in pulse cycle ignored", v, 16'h0140);

    p0 = pulses;
    wr(A_KEY, 16'hD928);
    chk(rst_req == 1, "R4 second key without first", rst_req, 1);
    idle(1);
    chk(rst_req == 0, "R4 pulse one cycle", rst_req, 0);
    wr(A_KEY, 16'h0000);
    chk(rst_req == 1, "R4 garbage key while locked", rst_req, 1);
    idle(1);
    wr(A_KEY, 16'hC520); wr(A_KEY, 16'hC520);
    chk(rst_req == 1, "R4 repeated first key", rst_req, 1);
    idle(1);
    wr(A_KEY, 16'hC520); wr(A_KEY, 16'hD929);
    chk(rst_req == 1, "R4 wrong second key", rst_req, 1);
    idle(1);
    chk(pulses == p0 + 4, "R4 pulse count", pulses, p0 + 4);
    wr(A_CTRL, 16'h0F00);
    rd(v);
    chk(v == 16'h0140, "R10 locked after failed sequence", v, 16'h0140);

    wr(A_KEY, 16'hC520); wr(A_KEY, 16'hD928);
    idle(255);
    wr(A_CTRL, 16'h00A0);
    rd(v);
    chk(v == 16'h00A0, "R5 write at edge 256 accepted", v, 16'h00A0);
    wr(A_KEY, 16'hC520); wr(A_KEY, 16'hD928);
    idle(256);
    wr(A_CTRL, 16'h5550);
    rd(v);
    chk(v == 16'h00A0, "R5 write at edge 257 ignored", v, 16'h00A0);
    wr(A_CTRL, 16'h3330);
    rd(v);
    chk(v == 16'h00A0, "R5 relocked after window", v, 16'h00A0);

    bus_addr = A_CTRL; bus_rd = 0;
    #1 chk(bus_rdata == 0, "R7 no strobe reads zero", bus_rdata, 0);
    bus_addr = A_KEY; bus_rd = 1;
    #1 chk(bus_rdata == 0, "R7 other address reads zero", bus_rdata, 0);
    bus_rd = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule